// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a three-wire serial control link that gives a host access to a small bank of 8-bit configuration registers. The host pulls the frame-select line low, clocks bits in on the serial data input and raises frame-select to close the frame. The block has one serial data output. That output is tri-stated whenever the block is not returning read data, and an output-enable pin shows when it is driven.

Every frame opens with a 16-bit word sent most significant bit first. The word holds a direction bit, a 7-bit register index and an 8-bit data byte. Writes land directly in the addressed register. Reads work indirectly: a control register holds a burst bit and a 7-bit selection field, and a frame with the direction bit set and an all-zero index starts a read.

There are two read modes. A single read returns the selected register in the last byte slot of the frame. A burst read continues past 16 clocks and returns registers 1 up to the selected number, one byte after another.

Top module: `sctl_port`

## Requirements
- R1: A frame is the sequence of serial clock rising edges while `frm_n` is low. Bit 15 (first on the wire) is the direction bit (0 = write), bits 14:8 are the register index and bits 7:0 are the data. A write updates the indexed register on the 16th rising edge.
- R2: If `frm_n` rises before the 16th rising edge of a write frame, no register changes.
- R3: Writes to index 0 or to an index above `NUM_REGS` change nothing. Reading index 0 or an index above `NUM_REGS` returns 0x00.
- R4: `sdo_oe` is 0 and `sdo` is high-impedance while `frm_n` is high, and also for the first 8 clocks of every frame.
- R5: The control register is at index 11. Its bit 7 is the burst bit and bits 6:0 are the selection field. With the burst bit at 0, a read frame drives the selected register MSB first. The first bit is driven after the falling edge that follows rising edge 8, and `sdo` changes only on falling edges. Output stops after the falling edge that follows rising edge 16.
- R6: With the burst bit at 1 and a selection N, a read frame returns registers 1 through N as consecutive bytes, starting at the same point as in R5. After those bytes the output is high-impedance. When N is 0, nothing is driven.
- R7: Serial input bits that follow the 8-bit header of a read frame change no register, however long the frame runs.
- R8: A frame with the direction bit at 1 and a nonzero index is a no-op: no output and no register change.
- R9: Asserting `rst_n` low clears every register, including the control register, to 0x00.
- R10: Only the first 16 bits of a write frame count. Further bits in the same frame change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the register bank and frame logic |
| frm_n | input | 1 | Frame select, active low; high aborts and resets the frame |
| sck | input | 1 | Serial clock; input sampled on rising edge, output changed on falling edge |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output, high-impedance when not enabled |
| sdo_oe | output | 1 | High while `sdo` is driven |

## Verification
A wrong bit counter moves the returned byte, or the enable window, by whole clocks. This shows up within the first read frame as a rotated value or an enable edge at the wrong clock. A register written by the wrong decode, or at the wrong edge, stays hidden until that register is read back, so every write is followed at once by a read of the same register. A wrong word index in burst mode shows as bytes in the wrong order, or an enable that runs on past byte N, in the same frame that starts the burst.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   // Direction bit encoding on the wire
   localparam logic DIR_WRITE = 1'b0;
   localparam logic DIR_READ  = 1'b1;

   typedef enum logic {
      RDM_SINGLE = 1'b0,
      RDM_BURST  = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 11
) (
   input  logic              sck,
   input  logic              clr,
   input  logic              sdi,
   output logic [CNT_W-1:0]  cnt,
   output logic              is_rd,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);
   import sctl_pkg::*;

   localparam int HDR_BITS = 1 + IDX_W;
   localparam int FRAME    = HDR_BITS + DATA_W;
   localparam int SH_W     = FRAME - 1;

   logic [SH_W-1:0]     sh;
   logic [HDR_BITS-1:0] hdr_now;

   // header as it stands once the current bit is included
   assign hdr_now = {sh[HDR_BITS-2:0], sdi};

   always_ff @(posedge sck or posedge clr) begin
      if (clr) begin
         sh    <= '0;
         cnt   <= '0;
         is_rd <= 1'b0;
      end else begin
         sh <= {sh[SH_W-2:0], sdi};
         if (cnt != '1) cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(HDR_BITS - 1))
            is_rd <= (hdr_now[HDR_BITS-1] == DIR_READ) &&
                     (hdr_now[IDX_W-1:0] == '0);
      end
   end

   // commit happens on the edge that carries the last frame bit
   assign wr_en   = !clr && (cnt == CNT_W'(FRAME - 1)) &&
                    (sh[SH_W-1] == DIR_WRITE);
   assign wr_idx  = sh[SH_W-2 -: IDX_W];
   assign wr_data = {sh[DATA_W-2:0], sdi};
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank #(
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 7,
   parameter int DATA_W   = 8,
   parameter int CTRL_IDX = 11
) (
   input  logic              sck,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ctrl_val
);
   logic [DATA_W-1:0] mem [1:NUM_REGS];

   for (genvar g = 1; g <= NUM_REGS; g++) begin : g_reg
      always_ff @(posedge sck or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            mem[g] <= wr_data;
      end
   end

   // unimplemented indexes (0 and above NUM_REGS) read as zero
   always_comb begin
      rd_data = '0;
      for (int i = 1; i <= NUM_REGS; i++)
         if (rd_idx == IDX_W'(i)) rd_data = mem[i];
   end

   assign ctrl_val = mem[CTRL_IDX];
endmodule

// File: rtl/sctl_txsel.sv
module sctl_txsel #(
   parameter int IDX_W    = 7,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 11,
   parameter bit BURST_EN = 1'b1
) (
   input  logic              sck,
   input  logic              clr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              is_rd,
   input  logic              burst_bit,
   input  logic [IDX_W-1:0]  sel,
   input  logic [DATA_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              sdo_bit,
   output logic              sdo_en
);
   import sctl_pkg::*;

   localparam int HDR_BITS = 1 + IDX_W;
   localparam int POS_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   rd_mode_e          mode;
   logic              in_body;
   logic              word_ok;
   logic [CNT_W-1:0]  offs;
   logic [CNT_W-1:0]  word;
   logic [POS_W-1:0]  pos;
   logic [DATA_W-1:0] shifted;

   if (BURST_EN) begin : g_burst
      assign mode = burst_bit ? RDM_BURST : RDM_SINGLE;
   end else begin : g_single
      assign mode = RDM_SINGLE;
   end

   always_comb begin
      in_body = (cnt >= CNT_W'(HDR_BITS));
      offs    = in_body ? (cnt - CNT_W'(HDR_BITS)) : '0;
      word    = offs / CNT_W'(DATA_W);
      pos     = POS_W'(offs % CNT_W'(DATA_W));
      if (mode == RDM_BURST) begin
         word_ok = (word < CNT_W'(sel));
         rd_idx  = IDX_W'(word + 1'b1);
      end else begin
         word_ok = (word == '0);
         rd_idx  = sel;
      end
      shifted = rd_data << pos;
   end

   always_ff @(negedge sck or posedge clr) begin
      if (clr) begin
         sdo_en  <= 1'b0;
         sdo_bit <= 1'b0;
      end else begin
         sdo_en  <= is_rd && in_body && word_ok;
         sdo_bit <= shifted[DATA_W-1];
      end
   end
endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = 7,
   parameter int DATA_W   = 8,
   parameter int CTRL_IDX = 11,
   parameter bit BURST_EN = 1'b1
) (
   input  logic rst_n,
   input  logic frm_n,
   input  logic sck,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);
   localparam int HDR_BITS = 1 + IDX_W;
   localparam int MAX_CLKS = HDR_BITS + DATA_W * ((2 ** IDX_W) - 1) + 1;
   localparam int CNT_W    = $clog2(MAX_CLKS + 1);
   localparam int BURST_POS = IDX_W;

   if (NUM_REGS < 1 || NUM_REGS >= (2 ** IDX_W)) begin : g_chk_num
      $error("NUM_REGS out of range for IDX_W");
   end
   if (CTRL_IDX < 1 || CTRL_IDX > NUM_REGS) begin : g_chk_ctrl
      $error("CTRL_IDX must name an implemented register");
   end
   if (DATA_W < IDX_W + 1) begin : g_chk_w
      $error("DATA_W too narrow for burst bit and selection field");
   end

   logic              clr;
   logic [CNT_W-1:0]  cnt;
   logic              is_rd;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] ctrl_val;
   logic              ctrl_burst;
   logic              sdo_bit;

   assign clr        = frm_n | ~rst_n;
   assign ctrl_burst = ctrl_val[BURST_POS];

   sctl_shift #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
      .sck(sck), .clr(clr), .sdi(sdi), .cnt(cnt), .is_rd(is_rd),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   sctl_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DATA_W(DATA_W),
               .CTRL_IDX(CTRL_IDX)) u_bank (
      .sck(sck), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .ctrl_val(ctrl_val)
   );

   sctl_txsel #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                .BURST_EN(BURST_EN)) u_tx (
      .sck(sck), .clr(clr), .cnt(cnt), .is_rd(is_rd),
      .burst_bit(ctrl_burst), .sel(ctrl_val[IDX_W-1:0]),
      .rd_data(rd_data), .rd_idx(rd_idx), .sdo_bit(sdo_bit),
      .sdo_en(sdo_oe)
   );

   assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk (
   input logic sck,
   input logic frm_n,
   input logic rst_n,
   input logic sdo_oe,
   input logic wr_en,
   input logic burst_bit,
   input logic rd_active
);
   logic [11:0] cc;

   // independent count of rising edges in the current frame
   always_ff @(posedge sck or posedge frm_n) begin
      if (frm_n)           cc <= '0;
      else if (cc != '1)   cc <= cc + 1'b1;
   end

   p_idle_hiz_r4: assert property (@(posedge sck) disable iff (!rst_n)
      frm_n |-> !sdo_oe);

   p_hdr_hiz_r4: assert property (@(posedge sck) disable iff (frm_n || !rst_n)
      (cc < 12'd8) |-> !sdo_oe);

   p_commit_edge_r1: assert property (@(posedge sck) disable iff (frm_n || !rst_n)
      wr_en |-> (cc == 12'd15));

   p_single_end_r5: assert property (@(posedge sck) disable iff (frm_n || !rst_n)
      (!burst_bit && cc >= 12'd16) |-> !sdo_oe);

   p_oe_read_only_r8: assert property (@(posedge sck) disable iff (frm_n || !rst_n)
      sdo_oe |-> rd_active);
endmodule

bind sctl_port sctl_port_chk u_chk (
   .sck(sck), .frm_n(frm_n), .rst_n(rst_n), .sdo_oe(sdo_oe),
   .wr_en(wr_en), .burst_bit(ctrl_burst), .rd_active(is_rd)
);

// File: tb/sctl_port_tb.sv
`timescale 1ns/1ps
module sctl_port_tb;
   localparam int CLK_PERIOD = 100;
   localparam int HALF = CLK_PERIOD / 2;
   localparam int NV = 6;
   // {index, data}
   localparam logic [14:0] VEC [0:NV-1] = '{
      {7'd1,  8'hA5}, {7'd2,  8'h3C}, {7'd7,  8'hFF},
      {7'd16, 8'h81}, {7'd9,  8'h00}, {7'd4,  8'h6E}
   };

   logic rst_n, frm_n, sck, sdi;
   logic sdo, sdo_oe;
   int   errs = 0, checks = 0;
   bit   done = 0;
   logic cap_oe [1:1100];
   logic cap_d  [1:1100];

   sctl_port u_dut (.rst_n(rst_n), .frm_n(frm_n), .sck(sck), .sdi(sdi),
                    .sdo(sdo), .sdo_oe(sdo_oe));

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [15:0] w, input int n, input logic [15:0] tail);
      frm_n = 1'b0;
      #(HALF);
      for (int k = 1; k <= n; k++) begin
         sck = 1'b0;
         sdi = (k <= 16) ? w[16 - k] : tail[15 - ((k - 17) % 16)];
         #(HALF);
         cap_oe[k] = sdo_oe;
         cap_d[k]  = sdo;
         sck = 1'b1;
         #(HALF);
      end
      #(HALF / 2);
      frm_n = 1'b1;
      #(CLK_PERIOD);
   endtask

   task automatic wr(input logic [6:0] idx, input logic [7:0] d);
      frame({1'b0, idx, d}, 16, 16'h0);
   endtask

   task automatic set_ctrl(input logic burst, input logic [6:0] sel);
      wr(7'd11, {burst, sel});
   endtask

   // byte at capture slots first..first+7
   function automatic logic [7:0] byte_at(input int first);
      logic [7:0] b;
      for (int i = 0; i < 8; i++) b[7 - i] = cap_d[first + i];
      return b;
   endfunction

   // number of clocks whose enable differs from the window lo..hi
   function automatic int oe_miss(input int n, input int lo, input int hi);
      int m = 0;
      for (int k = 1; k <= n; k++)
         if (cap_oe[k] !== ((k >= lo && k <= hi) ? 1'b1 : 1'b0)) m++;
      return m;
   endfunction

   task automatic rd_single(input logic [6:0] sel, output logic [7:0] v, output int miss);
      set_ctrl(1'b0, sel);
      frame(16'h8000, 18, 16'h0);
      v = byte_at(9);
      miss = oe_miss(18, 9, 16);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int miss;
      rst_n = 1'b0; frm_n = 1'b1; sck = 1'b1; sdi = 1'b0;
      #(CLK_PERIOD * 2);
      check("R4 idle oe", {31'd0, sdo_oe}, 32'd0);
      check("R4 idle sdo z", {31'd0, sdo === 1'bz}, 32'd1);
      rst_n = 1'b1;
      #(CLK_PERIOD);

      rd_single(7'd3, v, miss);
      check("R9 reset value", {24'd0, v}, 32'h00);

      // table walk: write then read back each entry (R1, R5, R4)
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][14:8], VEC[i][7:0]);
         rd_single(VEC[i][14:8], v, miss);
         check("R1 R5 readback", {24'd0, v}, {24'd0, VEC[i][7:0]});
         check("R4 R5 enable window", miss, 0);
      end

      // R2: partial write aborted
      frame({1'b0, 7'd2, 8'h55}, 12, 16'h0);
      rd_single(7'd2, v, miss);
      check("R2 partial write", {24'd0, v}, 32'h3C);

      // R3: writes to 0 and beyond bank, reads there
      wr(7'd0, 8'h99);
      wr(7'd20, 8'h77);
      rd_single(7'd20, v, miss);
      check("R3 read beyond bank", {24'd0, v}, 32'h00);
      check("R3 enable still on", miss, 0);
      rd_single(7'd0, v, miss);
      check("R3 read index 0", {24'd0, v}, 32'h00);

      // R10: write frame with extra bits resembling a write to reg 3
      frame({1'b0, 7'd2, 8'h11}, 32, {1'b0, 7'd3, 8'h77});
      rd_single(7'd2, v, miss);
      check("R10 first 16 bits commit", {24'd0, v}, 32'h11);
      rd_single(7'd3, v, miss);
      check("R10 trailing bits ignored", {24'd0, v}, 32'h00);

      // R7: read frame with trailing bits resembling a write to reg 3
      set_ctrl(1'b0, 7'd1);
      frame(16'h80EE, 32, {1'b0, 7'd3, 8'h44});
      check("R7 read frame output", {24'd0, byte_at(9)}, 32'hA5);
      rd_single(7'd3, v, miss);
      check("R7 read frame no write", {24'd0, v}, 32'h00);

      // R8: direction read with nonzero index
      set_ctrl(1'b0, 7'd1);
      frame({1'b1, 7'd5, 8'h00}, 18, 16'h0);
      check("R8 no output", oe_miss(18, 99, 0), 0);
      rd_single(7'd5, v, miss);
      check("R8 no register change", {24'd0, v}, 32'h00);

      // R6: burst of registers 1..4
      wr(7'd3, 8'hC7);
      set_ctrl(1'b1, 7'd4);
      frame(16'h8000, 48, 16'h0);
      check("R6 burst word1", {24'd0, byte_at(9)},  32'hA5);
      check("R6 burst word2", {24'd0, byte_at(17)}, 32'h11);
      check("R6 burst word3", {24'd0, byte_at(25)}, 32'hC7);
      check("R6 burst word4", {24'd0, byte_at(33)}, 32'h6E);
      check("R6 burst enable window", oe_miss(48, 9, 40), 0);

      // R6: burst with N = 0
      set_ctrl(1'b1, 7'd0);
      frame(16'h8000, 24, 16'h0);
      check("R6 burst N=0 silent", oe_miss(24, 99, 0), 0);

      // R9: reset clears bank and control register
      rst_n = 1'b0;
      #(CLK_PERIOD);
      rst_n = 1'b1;
      #(CLK_PERIOD);
      frame(16'h8000, 18, 16'h0);
      check("R9 control cleared, reg0 read", {24'd0, byte_at(9)}, 32'h00);
      rd_single(7'd1, v, miss);
      check("R9 reg1 cleared", {24'd0, v}, 32'h00);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule